// File: doc/BRIEF.md
# Dynamic Thread-to-Port Scheduler

This block pairs idle worker threads with receive ports that hold a waiting packet, so that any free thread can serve any port instead of each thread being tied to one port. A thread that wants work offers its identifier on an enqueue handshake. The identifier joins a first-in first-out thread queue, and the thread then sleeps until it is woken.

A scan pointer walks the port-ready status vector one bit per clock in round-robin order. When the bit under the pointer is set and the queue holds at least one thread, the block issues an assignment in that same cycle. The assignment carries the identifier of the thread at the head of the queue and the port number, and it serves as the wake strobe for that thread. In the same cycle the block raises a one-hot clear for that port's ready bit and removes the head entry from the queue. The block drives the current queue occupancy out at all times, so that a power controller can compare it with a threshold and decide when to gate processing elements.

The external status register that holds the ready bits applies the clear at the next clock edge. Moving the packet data is the job of other blocks.

Top module: `tps_sched`

## Requirements
- R1: Threads receive assignments in the order their identifiers were accepted. `asg_tid` is always the oldest identifier still in the queue.
- R2: While the queue is non-empty, the scan pointer moves forward by exactly one port per cycle, wrapping from port NUM_PORTS-1 to port 0. Testing m ports therefore costs m cycles.
- R3: After an assignment to port p, the next port tested is p+1 modulo NUM_PORTS. After reset the first port tested is port 0.
- R4: While the queue is empty, `asg_valid` stays low whatever the ready bits hold, and the scan pointer does not move.
- R5: An assignment is issued in the cycle where the queue is non-empty and `port_rdy` is set at the pointer. In that cycle `rdy_clr` is one-hot at `asg_port`; in every other cycle `rdy_clr` is all zeros.
- R6: `enq_ready` is low exactly when the queue holds QUEUE_DEPTH entries (24 by default). An enqueue attempted at that time is ignored and leaves `q_len` unchanged.
- R7: An accepted enqueue and an assignment may occur in the same cycle, and together they leave `q_len` unchanged.
- R8: `q_len` equals the number of thread identifiers accepted and not yet assigned. It updates one cycle after each enqueue or dequeue.
- R9: After reset, `q_len` is 0, `enq_ready` is 1 and `asg_valid` is 0.
- R10: An identifier accepted into an empty queue can be assigned in the very next cycle, but not in the cycle it is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | A thread offers its identifier |
| enq_tid | input | TID_W | Identifier of the offering thread |
| enq_ready | output | 1 | The queue can accept an identifier |
| port_rdy | input | NUM_PORTS | One bit per receive port: packet waiting |
| asg_valid | output | 1 | Assignment and wake strobe |
| asg_tid | output | TID_W | Thread being woken |
| asg_port | output | $clog2(NUM_PORTS) | Port given to that thread |
| rdy_clr | output | NUM_PORTS | One-hot clear for the assigned port's ready bit |
| q_len | output | $clog2(QUEUE_DEPTH+1) | Current thread queue occupancy |

## Verification
The hardest cases to reach from the ports are a full queue that is offered further identifiers while no port is ready, and a single ready port that the pointer must walk around to from a distant position. Directed phases create both: one holds all ready bits low while it pushes more than QUEUE_DEPTH identifiers, and one raises one port far from the current pointer. A long random phase then varies the enqueue rate and the port arrival density. It crosses light and heavy load many times, so that the queue passes through empty, full and simultaneous push-and-pop cycles, and every cycle is compared with a bench model of the queue and the pointer.

// File: rtl/tps_pkg.sv
package tps_pkg;
   // next index in a ring of n slots
   function automatic int ring_next(input int v, input int n);
      return (v >= n - 1) ? 0 : v + 1;
   endfunction
endpackage

// File: rtl/tps_fifo.sv
module tps_fifo #(
   parameter int DEPTH = 24,
   parameter int W     = 5
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  logic [W-1:0]               din,
   input  logic                       pop,
   output logic [W-1:0]               dout,
   output logic [$clog2(DEPTH+1)-1:0] count,
   output logic                       full,
   output logic                       empty
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) begin
            mem[wr_ptr] <= din;
            wr_ptr      <= PTR_W'(tps_pkg::ring_next(int'(wr_ptr), DEPTH));
         end
         if (pop)
            rd_ptr <= PTR_W'(tps_pkg::ring_next(int'(rd_ptr), DEPTH));
         case ({push, pop})
            2'b10:   count <= count + CNT_W'(1);
            2'b01:   count <= count - CNT_W'(1);
            default: count <= count;
         endcase
      end
   end

   assign dout  = mem[rd_ptr];
   assign full  = (count == CNT_W'(DEPTH));
   assign empty = (count == '0);
endmodule

// File: rtl/tps_scan.sv
module tps_scan #(
   parameter int NUM_PORTS = 16
) (
   input  logic                                         clk,
   input  logic                                         rst_n,
   input  logic                                         advance,
   output logic [((NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1)-1:0] ptr
);
   localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

   always_ff @(posedge clk) begin
      if (!rst_n)
         ptr <= '0;
      else if (advance)
         ptr <= PORT_W'(tps_pkg::ring_next(int'(ptr), NUM_PORTS));
   end
endmodule

// File: rtl/tps_sched.sv
module tps_sched #(
   parameter int NUM_PORTS   = 16,
   parameter int QUEUE_DEPTH = 24,
   parameter int TID_W       = 5
) (
   input  logic                                               clk,
   input  logic                                               rst_n,
   input  logic                                               enq_valid,
   input  logic [TID_W-1:0]                                   enq_tid,
   output logic                                               enq_ready,
   input  logic [NUM_PORTS-1:0]                               port_rdy,
   output logic                                               asg_valid,
   output logic [TID_W-1:0]                                   asg_tid,
   output logic [((NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1)-1:0] asg_port,
   output logic [NUM_PORTS-1:0]                               rdy_clr,
   output logic [$clog2(QUEUE_DEPTH+1)-1:0]                   q_len
);
   localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

   generate
      if (NUM_PORTS < 2) begin : g_bad_ports
         $error("tps_sched: NUM_PORTS must be at least 2");
      end
      if (QUEUE_DEPTH < 2) begin : g_bad_depth
         $error("tps_sched: QUEUE_DEPTH must be at least 2");
      end
      if (TID_W < 1) begin : g_bad_tid
         $error("tps_sched: TID_W must be positive");
      end
   endgenerate

   logic              q_full, q_empty, push, hit;
   logic [TID_W-1:0]  head_tid;
   logic [PORT_W-1:0] scan_ptr;

   assign enq_ready = !q_full;
   assign push      = enq_valid && !q_full;
   assign hit       = !q_empty && port_rdy[scan_ptr];

   tps_fifo #(.DEPTH(QUEUE_DEPTH), .W(TID_W)) u_queue (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .din   (enq_tid),
      .pop   (hit),
      .dout  (head_tid),
      .count (q_len),
      .full  (q_full),
      .empty (q_empty)
   );

   tps_scan #(.NUM_PORTS(NUM_PORTS)) u_scan (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (!q_empty),
      .ptr     (scan_ptr)
   );

   assign asg_valid = hit;
   assign asg_tid   = head_tid;
   assign asg_port  = scan_ptr;

   generate
      for (genvar g = 0; g < NUM_PORTS; g++) begin : g_clr
         assign rdy_clr[g] = hit && (scan_ptr == PORT_W'(g));
      end
   endgenerate
endmodule

// File: rtl/tps_sched_chk.sv
module tps_sched_chk #(
   parameter int NUM_PORTS   = 16,
   parameter int QUEUE_DEPTH = 24,
   parameter int TID_W       = 5
) (
   input logic                                               clk,
   input logic                                               rst_n,
   input logic                                               enq_valid,
   input logic                                               enq_ready,
   input logic [NUM_PORTS-1:0]                               port_rdy,
   input logic                                               asg_valid,
   input logic [((NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1)-1:0] asg_port,
   input logic [NUM_PORTS-1:0]                               rdy_clr,
   input logic [$clog2(QUEUE_DEPTH+1)-1:0]                   q_len,
   input logic [((NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1)-1:0] scan_ptr
);
   localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
   localparam int CNT_W  = $clog2(QUEUE_DEPTH + 1);

   function automatic logic [PORT_W-1:0] step_of(input logic [PORT_W-1:0] p);
      return (int'(p) == NUM_PORTS - 1) ? '0 : p + PORT_W'(1);
   endfunction

   // R5
   clr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      asg_valid |-> (rdy_clr == (NUM_PORTS'(1) << asg_port)) && port_rdy[asg_port]);

   // R5
   clr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !asg_valid |-> (rdy_clr == '0));

   // R4
   empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q_len == '0) |-> !asg_valid ##1 (scan_ptr == $past(scan_ptr)));

   // R2
   one_per_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q_len != '0) |=> (scan_ptr == step_of($past(scan_ptr))));

   // R6
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q_len <= CNT_W'(QUEUE_DEPTH)) && ((q_len == CNT_W'(QUEUE_DEPTH)) == !enq_ready));

   // R7
   push_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enq_valid && enq_ready && asg_valid) |=> $stable(q_len));

   // R8
   grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enq_valid && enq_ready && !asg_valid) |=> (q_len == $past(q_len) + CNT_W'(1)));

   // R3
   after_asg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      asg_valid |=> (scan_ptr == step_of($past(asg_port))));
endmodule

bind tps_sched tps_sched_chk #(
   .NUM_PORTS(NUM_PORTS), .QUEUE_DEPTH(QUEUE_DEPTH), .TID_W(TID_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_ready(enq_ready),
   .port_rdy(port_rdy), .asg_valid(asg_valid), .asg_port(asg_port),
   .rdy_clr(rdy_clr), .q_len(q_len), .scan_ptr(scan_ptr)
);

// File: tb/tps_sched_tb.sv
`timescale 1ns/1ps
module tps_sched_tb_top;
   localparam int NP = 16;
   localparam int QD = 24;
   localparam int TW = 5;
   localparam int WD_LIMIT = 150000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          enq_valid = 1'b0;
   logic [TW-1:0] enq_tid = '0;
   logic          enq_ready;
   logic [NP-1:0] port_rdy = '0;
   logic          asg_valid;
   logic [TW-1:0] asg_tid;
   logic [3:0]    asg_port;
   logic [NP-1:0] rdy_clr;
   logic [4:0]    q_len;

   always #2 clk = ~clk;

   tps_sched #(.NUM_PORTS(NP), .QUEUE_DEPTH(QD), .TID_W(TW)) dut_i (
      .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_tid(enq_tid),
      .enq_ready(enq_ready), .port_rdy(port_rdy), .asg_valid(asg_valid),
      .asg_tid(asg_tid), .asg_port(asg_port), .rdy_clr(rdy_clr), .q_len(q_len)
   );

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 0;

   // bench model
   int            mq[$];
   int            mptr = 0;
   logic [NP-1:0] prdy = '0;
   bit            prev_both = 0;
   bit            prev_fill_empty = 0;

   function automatic int exp_len(input int n);
      return n;
   endfunction

   function automatic logic [NP-1:0] onehot_of(input int p);
      return NP'(1) << p;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   task automatic step(input bit ev, input int tid, input logic [NP-1:0] arrive);
      int  n;
      bit  ev_ok, hit_e;
      @(negedge clk);
      enq_valid = ev;
      enq_tid   = TW'(tid);
      prdy      = prdy | arrive;
      port_rdy  = prdy;
      #0.5;
      n     = mq.size();
      hit_e = (n > 0) && prdy[mptr];
      ev_ok = (n < QD);
      chk(prev_both ? "R7 q_len after push+pop" : "R8 q_len", int'(q_len), exp_len(n));
      chk("R6 enq_ready", int'(enq_ready), int'(ev_ok));
      if (n == 0)
         chk("R4 no assignment while empty", int'(asg_valid), 0);
      else
         chk(prev_fill_empty ? "R10 assignment after first accept" : "R2 R3 scan hit",
             int'(asg_valid), int'(hit_e));
      chk("R5 rdy_clr", int'(rdy_clr), int'(hit_e ? onehot_of(mptr) : NP'(0)));
      if (hit_e && asg_valid) begin
         chk("R1 asg_tid head of queue", int'(asg_tid), mq[0]);
         chk("R3 asg_port", int'(asg_port), mptr);
      end
      prev_both       = ev && ev_ok && hit_e;
      prev_fill_empty = (n == 0) && ev;
      if (hit_e) begin
         void'(mq.pop_front());
         prdy[mptr] = 1'b0;
      end
      if (n > 0) mptr = (mptr + 1) % NP;
      if (ev && ev_ok) mq.push_back(tid);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc >= WD_LIMIT && !done) begin
         done = 1;
         errors++;
         $display("FAIL watchdog: run did not complete, actual cycle %0d expected < %0d", cyc, WD_LIMIT);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      seed = $urandom(32'd271828);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #0.5;
      // R9 reset state
      chk("R9 reset q_len", int'(q_len), 0);
      chk("R9 reset enq_ready", int'(enq_ready), 1);
      chk("R9 reset asg_valid", int'(asg_valid), 0);

      // R4: ready ports but empty queue, pointer must stay at 0
      for (int i = 0; i < 5; i++) step(0, 0, 16'hFFFF);
      // R10 / R3: first thread goes to port 0
      step(1, 7, '0);
      for (int i = 0; i < 3; i++) step(1, 8 + i, '0);
      for (int i = 0; i < 40; i++) step(0, 0, '0);

      // R6: fill past capacity with nothing ready
      prdy = '0;
      for (int i = 0; i < QD + 6; i++) step(1, i % 32, '0);
      // R2: one distant port, pointer walks to it
      step(0, 0, onehot_of((mptr + 11) % NP));
      for (int i = 0; i < 14; i++) step(0, 0, '0);
      // R7: push while popping with all ports ready
      for (int i = 0; i < 30; i++) step(1, (i * 3) % 32, 16'hFFFF);
      for (int i = 0; i < 60; i++) step(0, 0, 16'hFFFF);

      // random phase with varied load
      for (int blk = 0; blk < 40; blk++) begin
         int pe = $urandom % 100;
         int pa = $urandom % 30;
         for (int i = 0; i < 150; i++) begin
            logic [NP-1:0] arr = '0;
            for (int b = 0; b < NP; b++)
               if (($urandom % 100) < pa) arr[b] = 1'b1;
            step(($urandom % 100) < pe, $urandom % 32, arr);
         end
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule